// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a 32-bit memory-mapped host reach a small register file that sits in a slow domain and is only one byte (or a few bytes) wide. The host never addresses the slow registers directly. It writes a command word that names the target register, the transfer direction and the byte lanes. A read begins as soon as that command is written. A write begins when the host then writes the value to the lower data register. While the downstream transfer is in flight, a busy bit in the command word reads as 1, and the host polls it before it uses the result or issues the next command.

Downstream, the bridge holds a request together with address, direction, lane strobes and write data until the slow side returns a one-cycle acknowledge, which also carries the read data. The bridge also collects two interrupt request lines into a flag register that is cleared by writing 1 and an enable register. It combines them into one interrupt output.

Top module: `irb_bridge`

## Requirements
- R1: After reset the command word, both data words, the enable and flag registers read 0. Offset 0x00 reads the ID_VALUE parameter. irq_out and dn_req are 0.
- R2: A host write to the command word at 0x04 with bit 24 = 1 (read) starts a downstream read of the register at bits 7:0. dn_req = 1 and dn_we = 0 from the next cycle. Once busy (bit 31) reads 0, the lower data word at 0x08 holds the result.
- R3: A command write with bit 24 = 0 arms a write and starts no transfer. The next lower-data write starts it, with dn_we = 1, the address from the command and the data from bits DN_W-1:0 of the written value. A lower-data write with no armed command starts nothing.
- R4: dn_req and its address stay steady until dn_ack. The cycle after dn_ack, dn_req is 0 and busy reads 0.
- R5: While busy, host writes to the command word, the lower data word and the upper data word (0x0C) are ignored.
- R6: Downstream lane k strobe is command bit 16+k (lower-word byte enable). On a write, a lane whose strobe is clear carries zero. On a read, a lane whose enable is clear loads zero into the lower data word.
- R7: The command word reads back size (bit 25), direction (bit 24), upper enables (23:20), lower enables (19:16) and address (7:0) as written, with busy in bit 31 and all other bits 0. The upper data word reads back as written.
- R8: Flag bit 1 (subsystem) and bit 0 (interface) at 0x14 set on a rising edge of irq_src[1] and irq_src[0]. Writing 1 clears a flag. A held level does not set the flag again. A rising edge in the same cycle as a clear leaves the flag set.
- R9: irq_out is 1 exactly when some flag bit and the same bit of the enable register at 0x10 are both 1.
- R10: Offsets 0x18 and above, and accesses that are not word aligned, read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_cs | input | 1 | Host access strobe, one cycle per access |
| hst_we | input | 1 | Host access is a write |
| hst_addr | input | HADDR_W | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, same cycle as hst_cs |
| dn_req | output | 1 | Downstream transfer request, held until dn_ack |
| dn_we | output | 1 | Downstream transfer is a write |
| dn_addr | output | 8 | Target register address |
| dn_strb | output | DN_BYTES | Downstream lane strobes |
| dn_wdata | output | 8*DN_BYTES | Downstream write data |
| dn_rdata | input | 8*DN_BYTES | Downstream read data, valid with dn_ack |
| dn_ack | input | 1 | One-cycle transfer acknowledge |
| irq_src | input | 2 | Interrupt requests: bit 1 subsystem, bit 0 interface |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench builds the bridge with DN_BYTES = 2 rather than the single-lane default. With two lanes, lane strobing and read masking can be told apart per lane: a single-lane build cannot show a masked upper byte. The slow-side model acknowledges after six cycles. That leaves room for several host writes to land while busy, so the ignore rule and the stable-request rule are both reached. Random addresses, data and lane enables are checked against a bench shadow of the slow registers.

// File: rtl/irb_pkg.sv
// Shared constants and types for the indirect register access bridge.
// Assumes a 32-bit host word and an 8-bit target address space.
package irb_pkg;
    localparam int unsigned HOST_DW = 32;
    localparam int unsigned TGT_AW  = 8;
    localparam int unsigned IRQ_N   = 2;

    // Command word bit positions decoded by the host side
    localparam int unsigned CB_BUSY = 31;
    localparam int unsigned CB_SIZE = 25;
    localparam int unsigned CB_DIR  = 24;
    localparam int unsigned CB_UBE  = 20;
    localparam int unsigned CB_LBE  = 16;

    // Word index of each host register (byte offset / 4)
    typedef enum logic [2:0] {
        W_ID    = 3'd0,
        W_CMD   = 3'd1,
        W_LDATA = 3'd2,
        W_UDATA = 3'd3,
        W_IEN   = 3'd4,
        W_IFLG  = 3'd5,
        W_RSV6  = 3'd6,
        W_RSV7  = 3'd7
    } word_e;

    // Stored command fields
    typedef struct packed {
        logic              size;
        logic              dir;
        logic [3:0]        ube;
        logic [3:0]        lbe;
        logic [TGT_AW-1:0] addr;
    } cmd_t;
endpackage

// File: rtl/irb_seq.sv
// Transfer sequencer: latches one launched transfer, holds the downstream
// request until the acknowledge, and returns lane-masked read data.
// Assumes launch is only raised while idle and dn_ack lasts one cycle.
module irb_seq #(
    parameter int unsigned DN_BYTES = 1,
    localparam int unsigned DN_W = 8 * DN_BYTES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      launch,
    input  logic                      l_we,
    input  logic [irb_pkg::TGT_AW-1:0] l_addr,
    input  logic [DN_BYTES-1:0]       l_strb,
    input  logic [DN_W-1:0]           l_wdata,
    output logic                      busy,
    output logic                      rd_done,
    output logic [DN_W-1:0]           rd_data,
    output logic                      dn_req,
    output logic                      dn_we,
    output logic [irb_pkg::TGT_AW-1:0] dn_addr,
    output logic [DN_BYTES-1:0]       dn_strb,
    output logic [DN_W-1:0]           dn_wdata,
    input  logic [DN_W-1:0]           dn_rdata,
    input  logic                      dn_ack
);
    logic [DN_W-1:0] wmask;

    // Per-lane masking of outgoing write data and returning read data
    for (genvar k = 0; k < DN_BYTES; k++) begin : g_lane
        assign wmask[k*8 +: 8]   = l_strb[k]  ? l_wdata[k*8 +: 8]  : 8'h00;
        assign rd_data[k*8 +: 8] = dn_strb[k] ? dn_rdata[k*8 +: 8] : 8'h00;

        // R6: a lane with its strobe clear carries zero while requesting
        assert_lane_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (dn_req && !dn_strb[k]) |-> (dn_wdata[k*8 +: 8] == 8'h00));
    end

    // Transfer state: set on launch, cleared by the acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            dn_we    <= 1'b0;
            dn_addr  <= '0;
            dn_strb  <= '0;
            dn_wdata <= '0;
        end else if (busy) begin
            if (dn_ack) busy <= 1'b0;
        end else if (launch) begin
            busy     <= 1'b1;
            dn_we    <= l_we;
            dn_addr  <= l_addr;
            dn_strb  <= l_strb;
            dn_wdata <= l_we ? wmask : '0;
        end
    end

    assign dn_req  = busy;
    assign rd_done = busy && dn_ack && !dn_we;

    // R4: request and address hold until acknowledged
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_ack) |=> (dn_req && $stable(dn_addr) && $stable(dn_we)));

    // R4: request drops the cycle after the acknowledge
    assert_ack_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_ack) |=> !dn_req);
endmodule

// File: rtl/irb_irq.sv
// Interrupt gathering: edge-detects each request line into a flag,
// clears flags written with 1, and gates them with an enable register.
// Assumes one host write per cycle to either register.
module irb_irq #(
    parameter int unsigned N = irb_pkg::IRQ_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src,
    input  logic         en_wr,
    input  logic         clr_wr,
    input  logic [N-1:0] wval,
    output logic [N-1:0] en_q,
    output logic [N-1:0] flg_q,
    output logic         irq_out
);
    logic [N-1:0] src_q;
    logic [N-1:0] rise;
    logic [N-1:0] clr;

    assign rise = src & ~src_q;
    assign clr  = clr_wr ? wval : '0;

    // Request history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src;
    end

    // Enable register, host written
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= wval;
    end

    // Flags: write-1 clear, a new edge wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= (flg_q & ~clr) | rise;
    end

    assign irq_out = |(flg_q & en_q);

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R8: a rising request sets its flag on the next cycle
        assert_edge_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> flg_q[i]);
    end

    // R9: nothing enabled means no interrupt
    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_out);
endmodule

// File: rtl/irb_bridge.sv
// Indirect register access bridge top: decodes the host register window,
// holds command and data words, launches transfers through the sequencer
// and maps the interrupt block. Assumes hst_cs lasts one cycle per access
// and that DN_BYTES is between 1 and 4.
module irb_bridge #(
    parameter logic [31:0] ID_VALUE = 32'h1B7D_0102,
    parameter int unsigned DN_BYTES = 1,
    parameter int unsigned HADDR_W  = 8,
    localparam int unsigned DN_W = 8 * DN_BYTES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hst_cs,
    input  logic               hst_we,
    input  logic [HADDR_W-1:0] hst_addr,
    input  logic [31:0]        hst_wdata,
    output logic [31:0]        hst_rdata,
    output logic               dn_req,
    output logic               dn_we,
    output logic [7:0]         dn_addr,
    output logic [DN_BYTES-1:0] dn_strb,
    output logic [DN_W-1:0]    dn_wdata,
    input  logic [DN_W-1:0]    dn_rdata,
    input  logic               dn_ack,
    input  logic [1:0]         irq_src,
    output logic               irq_out
);
    import irb_pkg::*;

    logic        hit;
    word_e       word;
    logic        wr_cmd, wr_ldata, wr_udata, wr_ien, wr_iflg;
    cmd_t        cmd_q;
    logic        armed;
    logic [31:0] ldata_q, udata_q;
    logic        busy, launch, l_we, rd_done;
    logic [TGT_AW-1:0]   l_addr;
    logic [DN_BYTES-1:0] l_strb;
    logic [DN_W-1:0]     rd_data;
    logic [IRQ_N-1:0]    ien_q, iflg_q;

    // Address decode: aligned words inside the first 32 bytes
    assign hit  = hst_cs && (hst_addr[1:0] == 2'b00) && (hst_addr[HADDR_W-1:5] == '0);
    assign word = word_e'(hst_addr[4:2]);

    assign wr_cmd   = hit && hst_we && (word == W_CMD);
    assign wr_ldata = hit && hst_we && (word == W_LDATA);
    assign wr_udata = hit && hst_we && (word == W_UDATA);
    assign wr_ien   = hit && hst_we && (word == W_IEN);
    assign wr_iflg  = hit && hst_we && (word == W_IFLG);

    // Command register: captured only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '0;
        else if (wr_cmd && !busy)
            cmd_q <= '{size: hst_wdata[CB_SIZE], dir: hst_wdata[CB_DIR],
                       ube: hst_wdata[CB_UBE +: 4], lbe: hst_wdata[CB_LBE +: 4],
                       addr: hst_wdata[TGT_AW-1:0]};
    end

    // Write arming: a write command waits for the following data write
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else if (!busy) begin
            if (wr_cmd)                armed <= !hst_wdata[CB_DIR];
            else if (wr_ldata && armed) armed <= 1'b0;
        end
    end

    // Launch selection: a read command goes at once, an armed write on data
    assign launch = !busy && ((wr_cmd && hst_wdata[CB_DIR]) || (wr_ldata && armed));
    assign l_we   = !wr_cmd;
    assign l_addr = wr_cmd ? hst_wdata[TGT_AW-1:0] : cmd_q.addr;
    assign l_strb = wr_cmd ? hst_wdata[CB_LBE +: DN_BYTES] : cmd_q.lbe[DN_BYTES-1:0];

    // Lower data: read result or idle host write
    always_ff @(posedge clk) begin
        if (!rst_n)                 ldata_q <= '0;
        else if (rd_done)           ldata_q <= 32'(rd_data);
        else if (wr_ldata && !busy) ldata_q <= hst_wdata;
    end

    // Upper data: plain host storage, frozen while busy
    always_ff @(posedge clk) begin
        if (!rst_n)                 udata_q <= '0;
        else if (wr_udata && !busy) udata_q <= hst_wdata;
    end

    irb_seq #(.DN_BYTES(DN_BYTES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .l_we    (l_we),
        .l_addr  (l_addr),
        .l_strb  (l_strb),
        .l_wdata (hst_wdata[DN_W-1:0]),
        .busy    (busy),
        .rd_done (rd_done),
        .rd_data (rd_data),
        .dn_req  (dn_req),
        .dn_we   (dn_we),
        .dn_addr (dn_addr),
        .dn_strb (dn_strb),
        .dn_wdata(dn_wdata),
        .dn_rdata(dn_rdata),
        .dn_ack  (dn_ack)
    );

    irb_irq #(.N(IRQ_N)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (irq_src),
        .en_wr   (wr_ien),
        .clr_wr  (wr_iflg),
        .wval    (hst_wdata[IRQ_N-1:0]),
        .en_q    (ien_q),
        .flg_q   (iflg_q),
        .irq_out (irq_out)
    );

    // Host read mux, combinational
    always_comb begin
        hst_rdata = '0;
        if (hit) begin
            case (word)
                W_ID:    hst_rdata = ID_VALUE;
                W_CMD:   hst_rdata = {busy, 5'd0, cmd_q.size, cmd_q.dir,
                                      cmd_q.ube, cmd_q.lbe, 8'd0, cmd_q.addr};
                W_LDATA: hst_rdata = ldata_q;
                W_UDATA: hst_rdata = udata_q;
                W_IEN:   hst_rdata = 32'(ien_q);
                W_IFLG:  hst_rdata = 32'(iflg_q);
                default: hst_rdata = '0;
            endcase
        end
    end

    // R5: a command write while busy leaves the command untouched
    assert_cmd_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && busy) |=> $stable(cmd_q));

    // R3: a data write with nothing armed starts no transfer
    assert_no_unarmed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ldata && !armed && !busy) |=> !busy);

    // R2: an idle read command starts a downstream read
    assert_read_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && hst_wdata[CB_DIR] && !busy) |=> (dn_req && !dn_we));
endmodule

// File: tb/irb_bridge_test.sv
module irb_bridge_test;
    localparam int NB = 2;
    localparam int DW = 8 * NB;
    localparam int LAT = 6;
    localparam logic [31:0] IDV = 32'h5EC0_77A1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hst_cs = 1'b0, hst_we = 1'b0;
    logic [7:0]  hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic dn_req, dn_we, dn_ack;
    logic [7:0] dn_addr;
    logic [NB-1:0] dn_strb;
    logic [DW-1:0] dn_wdata, dn_rdata;
    logic [1:0] irq_src = 2'b00;
    logic irq_out;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [DW-1:0] mem [256];
    logic [DW-1:0] shadow [256];
    int cnt;

    always #5 clk = ~clk;

    irb_bridge #(.ID_VALUE(IDV), .DN_BYTES(NB), .HADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .hst_cs(hst_cs), .hst_we(hst_we),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_strb(dn_strb),
        .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_ack(dn_ack),
        .irq_src(irq_src), .irq_out(irq_out));

    // Slow-side model: fixed-latency acknowledge, per-lane write strobes
    always @(posedge clk) begin
        if (!rst_n) begin
            dn_ack <= 1'b0; cnt <= 0; dn_rdata <= '0;
        end else begin
            dn_ack <= 1'b0;
            if (dn_req && !dn_ack) begin
                if (cnt == LAT - 1) begin
                    cnt <= 0;
                    dn_ack <= 1'b1;
                    if (dn_we) begin
                        for (int k = 0; k < NB; k++)
                            if (dn_strb[k]) mem[dn_addr][k*8 +: 8] <= dn_wdata[k*8 +: 8];
                    end else
                        dn_rdata <= mem[dn_addr];
                end else cnt <= cnt + 1;
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        hst_cs = 1; hst_we = 1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_cs = 0; hst_we = 0;
    endtask

    task automatic host_rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        hst_cs = 1; hst_we = 0; hst_addr = a;
        #1 d = hst_rdata;
        hst_cs = 0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 100; i++) begin
            host_rd(8'h04, v);
            if (!v[31]) return;
        end
        check("R4 busy timeout", 32'd1, 32'd0);
    endtask

    function automatic logic [31:0] cmd(bit rd, logic [3:0] lbe, logic [7:0] a);
        return {7'd0, rd, 4'd0, lbe, 8'd0, a};
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] a, logic [3:0] lbe);
        logic [31:0] r = '0;
        for (int k = 0; k < NB; k++)
            if (lbe[k]) r[k*8 +: 8] = shadow[a][k*8 +: 8];
        return r;
    endfunction

    function automatic logic [DW-1:0] lane_mask(logic [DW-1:0] d, logic [3:0] lbe);
        logic [DW-1:0] r = '0;
        for (int k = 0; k < NB; k++)
            if (lbe[k]) r[k*8 +: 8] = d[k*8 +: 8];
        return r;
    endfunction

    task automatic do_write(logic [7:0] a, logic [3:0] lbe, logic [15:0] d);
        host_wr(8'h04, cmd(0, lbe, a));
        host_wr(8'h08, {16'd0, d});
        wait_idle();
        for (int k = 0; k < NB; k++)
            if (lbe[k]) shadow[a][k*8 +: 8] = d[k*8 +: 8];
    endtask

    task automatic do_read(logic [7:0] a, logic [3:0] lbe, output logic [31:0] v);
        host_rd(8'h04, v);
        host_wr(8'h04, cmd(1, lbe, a));
        wait_idle();
        host_rd(8'h08, v);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0] a;
        logic [3:0] wb, rb;
        logic [15:0] d;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) begin mem[i] = '0; shadow[i] = '0; end
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        host_rd(8'h00, v); check("R1 id", v, IDV);
        host_rd(8'h04, v); check("R1 cmd", v, 0);
        host_rd(8'h08, v); check("R1 ldata", v, 0);
        host_rd(8'h0C, v); check("R1 udata", v, 0);
        host_rd(8'h10, v); check("R1 ien", v, 0);
        host_rd(8'h14, v); check("R1 iflg", v, 0);
        check("R1 irq_out", 32'(irq_out), 0);
        check("R1 dn_req", 32'(dn_req), 0);

        // R3 write: command arms, data launches
        host_wr(8'h04, cmd(0, 4'h3, 8'h12));
        check("R3 no launch on cmd", 32'(dn_req), 0);
        host_wr(8'h08, 32'h0000_BEEF);
        check("R3 launch req", 32'(dn_req), 1);
        check("R3 dn_we", 32'(dn_we), 1);
        check("R3 dn_addr", 32'(dn_addr), 32'h12);
        check("R3 dn_wdata", 32'(dn_wdata), 32'hBEEF);
        check("R6 dn_strb", 32'(dn_strb), 3);
        host_rd(8'h04, v); check("R4 busy set", 32'(v[31]), 1);
        while (!dn_ack) @(negedge clk);
        @(negedge clk);
        check("R4 req drops after ack", 32'(dn_req), 0);
        host_rd(8'h04, v); check("R4 busy clear", 32'(v[31]), 0);
        shadow[8'h12] = 16'hBEEF;

        // R3 unarmed data write starts nothing
        host_wr(8'h08, 32'h0000_1234);
        check("R3 unarmed no launch", 32'(dn_req), 0);

        // R2 read
        host_wr(8'h04, cmd(1, 4'h3, 8'h12));
        check("R2 read req", 32'(dn_req), 1);
        check("R2 read dir", 32'(dn_we), 0);
        check("R2 read addr", 32'(dn_addr), 32'h12);
        wait_idle();
        host_rd(8'h08, v); check("R2 read result", v, 32'h0000_BEEF);

        // R6 partial lanes
        host_wr(8'h04, cmd(0, 4'h1, 8'h20));
        host_wr(8'h08, 32'h0000_A5C3);
        check("R6 strb lane0", 32'(dn_strb), 1);
        check("R6 masked wdata", 32'(dn_wdata), 32'h00C3);
        wait_idle();
        shadow[8'h20][7:0] = 8'hC3;
        do_read(8'h12, 4'h2, v); check("R6 read lane mask", v, 32'h0000_BE00);
        host_wr(8'h04, cmd(0, 4'h0, 8'h21));
        host_wr(8'h08, 32'h0000_FFFF);
        check("R6 no lanes wdata", 32'(dn_wdata), 0);
        wait_idle();
        do_read(8'h21, 4'h3, v); check("R6 no lanes untouched", v, 0);

        // R5 writes ignored while busy
        host_wr(8'h0C, 32'hCAFE_0001);
        host_wr(8'h04, cmd(1, 4'h3, 8'h12));
        host_wr(8'h04, 32'h0103_0055);
        host_wr(8'h08, 32'h0000_1111);
        host_wr(8'h0C, 32'h0000_2222);
        wait_idle();
        host_rd(8'h04, v); check("R5 cmd kept", v, cmd(1, 4'h3, 8'h12));
        host_rd(8'h08, v); check("R5 ldata kept", v, 32'h0000_BEEF);
        host_rd(8'h0C, v); check("R5 udata kept", v, 32'hCAFE_0001);

        // R7 readback of fields
        host_wr(8'h04, 32'hFEFF_FFFF);
        host_rd(8'h04, v); check("R7 cmd fields", v, 32'h02FF_00FF);
        host_wr(8'h0C, 32'h1234_5678);
        host_rd(8'h0C, v); check("R7 udata", v, 32'h1234_5678);

        // R10 unmapped and misaligned
        host_wr(8'h18, 32'hFFFF_FFFF);
        host_wr(8'h2C, 32'hFFFF_FFFF);
        host_wr(8'h0D, 32'h0000_0000);
        host_rd(8'h18, v); check("R10 read 0x18", v, 0);
        host_rd(8'h1C, v); check("R10 read 0x1C", v, 0);
        host_rd(8'h09, v); check("R10 misaligned", v, 0);
        host_rd(8'h0C, v); check("R10 udata unchanged", v, 32'h1234_5678);
        check("R10 no launch", 32'(dn_req), 0);
        host_wr(8'h04, cmd(0, 4'h3, 8'h00));

        // R8 / R9 interrupts
        @(negedge clk) irq_src = 2'b10;
        host_rd(8'h14, v); check("R8 subsystem flag", v, 2);
        check("R9 masked", 32'(irq_out), 0);
        host_wr(8'h10, 32'h2);
        check("R9 enabled irq", 32'(irq_out), 1);
        host_wr(8'h14, 32'h2);
        host_rd(8'h14, v); check("R8 level no reset", v, 0);
        check("R9 cleared irq", 32'(irq_out), 0);
        @(negedge clk) irq_src = 2'b01;
        host_rd(8'h14, v); check("R8 interface flag", v, 1);
        check("R9 other enable", 32'(irq_out), 0);
        host_wr(8'h10, 32'h3);
        check("R9 both enabled", 32'(irq_out), 1);
        @(negedge clk);
        hst_cs = 1; hst_we = 1; hst_addr = 8'h14; hst_wdata = 32'h2;
        irq_src = 2'b11;
        @(negedge clk);
        hst_cs = 0; hst_we = 0;
        host_rd(8'h14, v); check("R8 edge beats clear", v, 3);
        host_wr(8'h14, 32'h3);
        host_rd(8'h14, v); check("R8 w1c both", v, 0);

        // Random write/read traffic against shadow (R2 R3 R6)
        for (int it = 0; it < 40; it++) begin
            a  = 8'($urandom);
            wb = 4'($urandom);
            rb = 4'($urandom_range(3, 1));
            d  = 16'($urandom);
            host_wr(8'h04, cmd(0, wb, a));
            host_wr(8'h08, {16'd0, d});
            check("R6 rand wdata", 32'(dn_wdata), 32'(lane_mask(d, wb)));
            wait_idle();
            for (int k = 0; k < NB; k++)
                if (wb[k]) shadow[a][k*8 +: 8] = d[k*8 +: 8];
            do_read(a, rb, v);
            check("R2 rand read", v, exp_read(a, rb));
        end

        done = 1;
        finish_run();
    end
endmodule